// File: doc/BRIEF.md
# Burst-Mode Oversampled Phase Selector

This block finds the sampling phase for each upstream burst on a receiver whose data is frequency locked to the local clock but arrives at an arbitrary phase. Once per bit period it takes a vector of samples of the serial line. The samples come from evenly spaced phases of the bit clock, with index 0 the earliest. While the alternating preamble at the head of a burst is arriving, it locates the bit boundary inside that vector and counts how often the boundary lands on the same index. Once enough consecutive agreements have been seen, it fixes the sample phase half a bit away from the boundary. That phase is held for the rest of the burst.

After lock, the sample at the chosen phase is retimed through a fixed pipeline onto a single serial data output, and a lock flag is raised. Before lock, the data output is held low. A synchronous burst reset, pulsed between bursts, clears the acquisition so the next burst can settle on its own phase. The clock itself is never switched. Only the choice of sample changes.

Top module: `burst_phase_sel`

## Requirements
- R1: A transition is located at index i (1..NPH-1) when samples i and i-1 of a vector differ, and at index 0 when sample 0 differs from sample NPH-1 of the previous vector. The index-0 comparison is suppressed for the first vector after a burst reset or after reset.
- R2: The chosen phase is the agreed transition index plus NPH/2, modulo NPH. After lock, the data output reproduces, for each vector, the sample at the chosen phase.
- R3: A vector with exactly one transition, at the same index as the current estimate, advances the agreement count. When the count reaches AGREE_N, lock_o rises at the clock edge that captures that vector.
- R4: A vector with exactly one transition at an index other than the estimate makes that index the new estimate with a count of 1. A vector with two or more transitions clears the count and the estimate.
- R5: A vector with no transition leaves the estimate and the count unchanged.
- R6: Once lock_o is high, the chosen phase and lock_o stay fixed until a burst reset, whatever the input carries.
- R7: sdo_o is low whenever lock_o is low. Vectors captured before the edge that raises lock_o never reach sdo_o; the first data bit shown is that of the vector which completed the lock.
- R8: burst_rst is synchronous and active high. After the edge at which it is high, lock_o and sdo_o are low, and the count, estimate, chosen phase and data pipeline are cleared.
- R9: While rst_n is low, lock_o and sdo_o are low. Release of rst_n is synchronised to clk.
- R10: A vector captured at edge n appears on sdo_o just after edge n+LAT-1, which is LAT edges counting the capture edge. It therefore appears no earlier than LAT-1 edges after lock_o rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock, runs continuously |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| burst_rst | input | 1 | Synchronous active-high restart of acquisition |
| samp_i | input | NPH | Line samples for one bit period, index 0 earliest |
| sdo_o | output | 1 | Retimed serial data, low until lock |
| lock_o | output | 1 | Phase acquired; stays high until burst reset |

## Verification
A wrong agreement count or estimate shows up as lock_o rising one or more bit periods earlier or later than the edge predicted from the preamble and any disturbed vectors. A wrong chosen phase shows as sdo_o carrying the sample from a neighbouring phase, which differs from the expected bit within LAT edges of lock for boundaries near the chosen sample. A pipeline or gating fault shows either as nonzero data before lock or as stale pre-lock samples in the first LAT-1 bits after lock. A burst reset that fails to clear state shows as lock arriving too soon in the following burst.

// File: rtl/bps_pkg.sv
package bps_pkg;

  typedef enum logic [1:0] {
    EDGE_NONE = 2'd0,
    EDGE_ONE  = 2'd1,
    EDGE_MANY = 2'd2
  } edge_cls_e;

endpackage

// File: rtl/bps_edge_detect.sv
module bps_edge_detect
  import bps_pkg::*;
#(
  parameter int NPH = 8,
  localparam int PW = $clog2(NPH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clr,
  input  logic [NPH-1:0] samp,
  output edge_cls_e      cls,
  output logic [PW-1:0]  idx
);

  logic           prev_q, prev_d;
  logic           have_q, have_d;
  logic [NPH-1:0] diff;
  logic           many;

  // wrap comparison only valid once a previous vector exists
  assign diff[0] = have_q & (samp[0] ^ prev_q);

  generate
    for (genvar g = 1; g < NPH; g++) begin : g_diff
      assign diff[g] = samp[g] ^ samp[g-1];
    end
  endgenerate

  // more than one bit set
  assign many = |(diff & (diff - NPH'(1)));

  always_comb begin
    idx = '0;
    for (int i = NPH - 1; i >= 0; i--) begin
      if (diff[i]) idx = PW'(i);
    end
  end

  always_comb begin
    if (diff == '0)  cls = EDGE_NONE;
    else if (many)   cls = EDGE_MANY;
    else             cls = EDGE_ONE;
  end

  always_comb begin
    if (clr) begin
      prev_d = 1'b0;
      have_d = 1'b0;
    end else begin
      prev_d = samp[NPH-1];
      have_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      have_q <= 1'b0;
    end else begin
      prev_q <= prev_d;
      have_q <= have_d;
    end
  end

endmodule

// File: rtl/bps_lock_ctrl.sv
module bps_lock_ctrl
  import bps_pkg::*;
#(
  parameter int NPH     = 8,
  parameter int AGREE_N = 4,
  localparam int PW = $clog2(NPH),
  localparam int CW = $clog2(AGREE_N + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  edge_cls_e     cls,
  input  logic [PW-1:0] idx,
  output logic          lock,
  output logic [PW-1:0] sel
);

  logic          lock_q, lock_d;
  logic [PW-1:0] sel_q, sel_d;
  logic [PW-1:0] est_q, est_d;
  logic          estv_q, estv_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          upd;

  // registers only change while acquiring or on a restart
  assign upd = clr | ~lock_q;

  always_comb begin
    lock_d = lock_q;
    sel_d  = sel_q;
    est_d  = est_q;
    estv_d = estv_q;
    cnt_d  = cnt_q;
    if (clr) begin
      lock_d = 1'b0;
      sel_d  = '0;
      est_d  = '0;
      estv_d = 1'b0;
      cnt_d  = '0;
    end else if (!lock_q) begin
      unique case (cls)
        EDGE_ONE: begin
          if (estv_q && (idx == est_q)) begin
            cnt_d = cnt_q + CW'(1);
          end else begin
            est_d  = idx;
            estv_d = 1'b1;
            cnt_d  = CW'(1);
          end
          if (cnt_d == CW'(AGREE_N)) begin
            lock_d = 1'b1;
            sel_d  = idx + PW'(NPH / 2);
          end
        end
        EDGE_MANY: begin
          cnt_d  = '0;
          estv_d = 1'b0;
        end
        default: begin
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q <= 1'b0;
      sel_q  <= '0;
      est_q  <= '0;
      estv_q <= 1'b0;
      cnt_q  <= '0;
    end else if (upd) begin
      lock_q <= lock_d;
      sel_q  <= sel_d;
      est_q  <= est_d;
      estv_q <= estv_d;
      cnt_q  <= cnt_d;
    end
  end

  assign lock = lock_q;
  assign sel  = sel_q;

endmodule

// File: rtl/bps_data_pipe.sv
module bps_data_pipe #(
  parameter int NPH = 8,
  parameter int LAT = 4,
  localparam int PW = $clog2(NPH),
  localparam int DL = LAT - 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clr,
  input  logic [NPH-1:0] samp,
  input  logic [PW-1:0]  sel,
  input  logic           lock,
  output logic           sdo
);

  logic [NPH-1:0] cap_q, cap_d;
  logic [DL-1:0]  dly_q, dly_d;
  logic [DL-1:0]  vld_q, vld_d;
  logic           sdo_q, sdo_d;

  always_comb begin
    if (clr) begin
      cap_d = '0;
      dly_d = '0;
      vld_d = '0;
      sdo_d = 1'b0;
    end else begin
      cap_d    = samp;
      dly_d    = '0;
      vld_d    = '0;
      dly_d[0] = cap_q[sel];
      vld_d[0] = lock;
      for (int i = 1; i < DL; i++) begin
        dly_d[i] = dly_q[i-1];
        vld_d[i] = vld_q[i-1];
      end
      sdo_d = vld_q[DL-1] & dly_q[DL-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_q <= '0;
      dly_q <= '0;
      vld_q <= '0;
      sdo_q <= 1'b0;
    end else begin
      cap_q <= cap_d;
      dly_q <= dly_d;
      vld_q <= vld_d;
      sdo_q <= sdo_d;
    end
  end

  assign sdo = sdo_q;

endmodule

// File: rtl/burst_phase_sel.sv
module burst_phase_sel
  import bps_pkg::*;
#(
  parameter int NPH     = 8,
  parameter int AGREE_N = 4,
  parameter int LAT     = 4,
  localparam int PW = $clog2(NPH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           burst_rst,
  input  logic [NPH-1:0] samp_i,
  output logic           sdo_o,
  output logic           lock_o
);

  logic [1:0]    rs_q;
  logic          arst_n;
  edge_cls_e     cls_w;
  logic [PW-1:0] idx_w;
  logic [PW-1:0] sel_w;
  logic          lock_w;

  // asynchronous assert, synchronous release (R9)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign arst_n = rs_q[1];

  bps_edge_detect #(.NPH(NPH)) u_edge (
    .clk   (clk),
    .rst_n (arst_n),
    .clr   (burst_rst),
    .samp  (samp_i),
    .cls   (cls_w),
    .idx   (idx_w)
  );

  bps_lock_ctrl #(.NPH(NPH), .AGREE_N(AGREE_N)) u_lock (
    .clk   (clk),
    .rst_n (arst_n),
    .clr   (burst_rst),
    .cls   (cls_w),
    .idx   (idx_w),
    .lock  (lock_w),
    .sel   (sel_w)
  );

  bps_data_pipe #(.NPH(NPH), .LAT(LAT)) u_pipe (
    .clk   (clk),
    .rst_n (arst_n),
    .clr   (burst_rst),
    .samp  (samp_i),
    .sel   (sel_w),
    .lock  (lock_w),
    .sdo   (sdo_o)
  );

  assign lock_o = lock_w;

endmodule

// File: rtl/burst_phase_sel_chk.sv
module burst_phase_sel_chk #(
  parameter int NPH = 8,
  localparam int PW = $clog2(NPH)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          burst_rst,
  input logic          lock_o,
  input logic          sdo_o,
  input logic [PW-1:0] sel
);

  p_lock_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_o && !burst_rst) |=> lock_o);

  p_sel_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_o && !burst_rst) |=> $stable(sel));

  p_quiet_unlocked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !lock_o |-> !sdo_o);

  p_brst_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    burst_rst |=> (!lock_o && !sdo_o));

  p_no_data_at_lock_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_o) |-> !sdo_o);

endmodule

bind burst_phase_sel burst_phase_sel_chk #(.NPH(NPH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .burst_rst (burst_rst),
  .lock_o    (lock_o),
  .sdo_o     (sdo_o),
  .sel       (sel_w)
);

// File: tb/burst_phase_sel_bench.sv
module burst_phase_sel_bench;

  localparam int NPH     = 8;
  localparam int AGREE_N = 4;
  localparam int LAT     = 4;
  localparam int NV      = 30;

  logic           clk;
  logic           rst_n;
  logic           burst_rst;
  logic [NPH-1:0] samp;
  logic           sdo;
  logic           lock;

  int n_chk;
  int n_bad;

  logic [NPH-1:0] vecs   [NV];
  logic           bits_a [NV+1];

  burst_phase_sel #(.NPH(NPH), .AGREE_N(AGREE_N), .LAT(LAT)) u_burst_phase_sel (
    .clk       (clk),
    .rst_n     (rst_n),
    .burst_rst (burst_rst),
    .samp_i    (samp),
    .sdo_o     (sdo),
    .lock_o    (lock)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [NPH-1:0] mk(logic cur, logic prv, int e);
    logic [NPH-1:0] v;
    for (int j = 0; j < NPH; j++) v[j] = (j >= e) ? cur : prv;
    return v;
  endfunction

  task automatic check(logic act, logic exp, string tag, string what);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %b expected %b", tag, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  // mode 0 plain preamble, 1 one vector with a shifted boundary,
  // 2 one vector with no transition, 3 one vector with several transitions
  task automatic run_burst(int e, int mode, int exp_l, int nv, string tag);
    int c;
    c = (e + NPH / 2) % NPH;
    bits_a[0] = 1'b0;
    for (int k = 0; k < NV; k++) begin
      logic b;
      if (k < 13) b = (k % 2 == 0);
      else        b = 1'($urandom % 2);
      if (mode == 2 && k >= 2 && k < 13) b = (k % 2 == 1);
      bits_a[k+1] = b;
    end
    for (int k = 0; k < NV; k++) begin
      vecs[k] = mk(bits_a[k+1], bits_a[k], e);
      if (mode == 1 && k == 2) vecs[k] = mk(bits_a[k+1], bits_a[k], 5);
      if (mode == 3 && k == 1) vecs[k] = vecs[k] ^ NPH'(8'h04);
    end
    @(negedge clk);
    burst_rst = 1'b1;
    samp      = '0;
    @(negedge clk);
    check(lock, 1'b0, "R8", "lock after burst reset");
    check(sdo, 1'b0, "R8", "data after burst reset");
    burst_rst = 1'b0;
    for (int k = 0; k < nv; k++) begin
      int  j;
      logic exp_d;
      samp = vecs[k];
      @(negedge clk);
      check(lock, logic'(k >= exp_l), tag, $sformatf("lock e=%0d vec=%0d", e, k));
      j = k - (LAT - 1);
      exp_d = (j >= 0 && j >= exp_l) ? vecs[j][c] : 1'b0;
      check(sdo, exp_d, "R2 R7 R10", $sformatf("data e=%0d vec=%0d", e, k));
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_bad++;
    $display("FAIL R3 watchdog: actual hung expected finished");
    summary();
    $finish;
  end

  initial begin
    n_chk     = 0;
    n_bad     = 0;
    rst_n     = 1'b0;
    burst_rst = 1'b0;
    samp      = '0;
    repeat (3) @(negedge clk);
    check(lock, 1'b0, "R9", "lock in reset");
    check(sdo, 1'b0, "R9", "data in reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(lock, 1'b0, "R9", "lock after release");
    check(sdo, 1'b0, "R9", "data after release");

    // R1 R3 R6: every boundary position, index 0 needs one more vector
    for (int e = 0; e < NPH; e++) begin
      run_burst(e, 0, (e == 0) ? AGREE_N : AGREE_N - 1, NV, "R1 R3 R6");
    end
    run_burst(2, 1, 6, NV, "R4 shifted");
    run_burst(3, 2, 4, NV, "R5 silent");
    run_burst(5, 3, 5, NV, "R4 multiple");
    // R8: interrupted acquisition must not carry its count forward
    run_burst(1, 0, 3, 2, "R8 partial");
    run_burst(1, 0, 3, NV, "R8 restart");
    run_burst(0, 0, 4, NV, "R1 R8 wrap");

    summary();
    $finish;
  end

endmodule